// File: doc/BRIEF.md
# Chained Indirect Effective Address Resolver

This block takes one 32-bit instruction word and works out where its operand lives, or what the operand is when the instruction carries its data inline. It covers four cases: a plain address, an address offset by one of three 18-bit index registers, a literal value, and pointer chains of any length where each fetched word may point further on. During a chain it issues word reads to main memory and waits for each reply. At every level it applies the index register named by the word in hand.

A controller hands it an instruction through a valid/ready pair. It then watches for a one-cycle completion pulse and picks up three results: the effective address, the operand value, and a flag saying whether that operand is already final (literal) or still has to be read from memory. The block refuses new work while a chain is running. A depth limit stops circular pointer chains and flags them as an error.

Top module: `eaddr_resolver`

## Requirements
- R1: Field positions in any word, with bit 31 as the most significant: bit 31 is the indirect flag, bits 30:29 select the index register, bit 28 is the literal flag and bits 16:0 are the address field. Bits 27:17 have no effect. The literal flag of words fetched during a chain has no effect: only the instruction's own literal flag counts.
- R2: At each level the level address is the address field plus an index value, taken modulo 2^18. Select code 0 adds zero, and codes 1, 2 and 3 add `idx1`, `idx2` and `idx3`.
- R3: An instruction with indirect=0 and literal=0 completes with `done` high on the second rising edge after acceptance. It issues no memory read, and it returns `ea` = level address, `operand_is_literal` = 0 and `operand` = 0.
- R4: An instruction with indirect=0 and literal=1 issues no memory read and returns `operand_is_literal` = 1, with `operand` equal to the level address zero-extended to 32 bits.
- R5: When the word in hand has indirect=1, the block reads memory at that word's level address. It holds `mem_req_valid` and `mem_req_addr` steady until `mem_rsp_valid`, and then continues with the returned word, until a word with indirect=0 is reached.
- R6: The index select of every word in a chain is applied at its own level, so the sequence of read addresses follows each word's own select code.
- R7: With instruction indirect=1 and literal=1, the final level address of the chain is returned as a literal operand (zero-extended) and is not read.
- R8: `start_ready` is low from the cycle after acceptance until completion. `start_valid` and `instr` presented while busy have no effect on the result.
- R9: `done` is a single-cycle pulse. `error` is 0 for every chain that ends within the depth limit.
- R10: At most MAX_DEPTH (default 16) reads are made per instruction. A chain whose 16th fetched word still has indirect=1 completes with `error` = 1, `ea` = the address that would have been read next, `operand` = 0 and `operand_is_literal` = 0. A chain ending on exactly the 16th read succeeds.
- R11: After reset, `start_ready` = 1, and `done`, `mem_req_valid`, `ea`, `operand`, `operand_is_literal` and `error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | An instruction is offered |
| start_ready | output | 1 | Block is idle and will take an instruction |
| instr | input | 32 | Instruction word |
| idx1 | input | 18 | Index register 1 contents |
| idx2 | input | 18 | Index register 2 contents |
| idx3 | input | 18 | Index register 3 contents |
| mem_req_valid | output | 1 | Word read request pending |
| mem_req_addr | output | 18 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 18 | Resolved effective address |
| operand | output | 32 | Literal operand, zero when not literal |
| operand_is_literal | output | 1 | Operand is final and needs no fetch |
| error | output | 1 | Depth limit reached |

## Verification
The sweep runs all four select codes with both flags in all four combinations, on address fields that include zero, all ones (forcing the 18-bit wrap) and two mixed patterns. Junk sits in the spare bits and in the literal bits of the fetched words. This separates the index select, the wrap, the literal-versus-address choice and any stray decoding of unused bits. Hand-built chains with a different select code at each level show whether indexing follows each fetched word rather than the instruction. Memory latency is varied so that the request hold and the response capture are exercised. Chains of exactly 16 and 17 levels, plus a self-pointing word, pin down the depth boundary, and attempted starts during a long chain show that the busy block ignores them.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  localparam int INSTR_W   = 32;
  localparam int AFIELD_W  = 17;
  localparam int IDX_SEL_W = 2;
  localparam int IDX_COUNT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } res_state_e;

  // Fields of one addressing level (instruction or fetched pointer word)
  typedef struct packed {
    logic                 ind;
    logic [IDX_SEL_W-1:0] sel;
    logic [AFIELD_W-1:0]  field;
  } level_t;

  function automatic level_t take_level(input logic [INSTR_W-1:0] w);
    level_t l;
    l.ind   = w[31];
    l.sel   = w[30:29];
    l.field = w[AFIELD_W-1:0];
    return l;
  endfunction

  function automatic logic take_lit(input logic [INSTR_W-1:0] w);
    return w[28];
  endfunction
endpackage

// File: rtl/eaddr_index_add.sv
module eaddr_index_add
  import eaddr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [IDX_SEL_W-1:0]             sel,
  input  logic [AFIELD_W-1:0]              field,
  input  logic [IDX_COUNT-1:0][ADDR_W-1:0] idx_regs,
  output logic [ADDR_W-1:0]                sum
);
  localparam int NCAND = IDX_COUNT + 1;

  // Sum of field and index, wrapping at the index register width
  function automatic logic [ADDR_W-1:0] wrap_sum(input logic [AFIELD_W-1:0] f,
                                                 input logic [ADDR_W-1:0] x);
    return ADDR_W'(f) + x;
  endfunction

  logic [NCAND-1:0][ADDR_W-1:0] cand;

  assign cand[0] = '0;
  for (genvar g = 1; g < NCAND; g++) begin : g_cand
    assign cand[g] = idx_regs[g-1];
  end

  assign sum = wrap_sum(field, cand[sel]);
endmodule

// File: rtl/eaddr_depth_ctr.sv
module eaddr_depth_ctr #(
  parameter int MAX_DEPTH = 16,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_limit = (count == LIMIT);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT);

  // R10
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/eaddr_resolver.sv
module eaddr_resolver
  import eaddr_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int MAX_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  idx1,
  input  logic [ADDR_W-1:0]  idx2,
  input  logic [ADDR_W-1:0]  idx3,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [INSTR_W-1:0] mem_rsp_data,
  output logic               done,
  output logic [ADDR_W-1:0]  ea,
  output logic [INSTR_W-1:0] operand,
  output logic               operand_is_literal,
  output logic               error
);
  localparam int CNT_W = $clog2(MAX_DEPTH + 1);

  res_state_e        state_q;
  level_t            level_q;
  logic              lit_mode_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [ADDR_W-1:0] level_addr;
  logic [CNT_W-1:0]  depth;
  logic              at_limit;

  logic [IDX_COUNT-1:0][ADDR_W-1:0] idx_regs;
  assign idx_regs = {idx3, idx2, idx1};

  // Named internal events
  logic accept_evt, in_eval, level_final, level_chase, limit_hit, rsp_take;
  assign accept_evt  = start_valid && (state_q == ST_IDLE);
  assign in_eval     = (state_q == ST_EVAL);
  assign level_final = in_eval && !level_q.ind;
  assign limit_hit   = in_eval && level_q.ind && at_limit;
  assign level_chase = in_eval && level_q.ind && !at_limit;
  assign rsp_take    = (state_q == ST_WAIT) && mem_rsp_valid;

  eaddr_index_add #(.ADDR_W(ADDR_W)) u_add (
    .sel      (level_q.sel),
    .field    (level_q.field),
    .idx_regs (idx_regs),
    .sum      (level_addr)
  );

  eaddr_depth_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept_evt),
    .inc      (level_chase),
    .count    (depth),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      level_q    <= '0;
      lit_mode_q <= 1'b0;
      req_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_evt) begin
          level_q    <= take_level(instr);
          lit_mode_q <= take_lit(instr);
          state_q    <= ST_EVAL;
        end
        ST_EVAL: begin
          if (level_chase) begin
            req_addr_q <= level_addr;
            state_q    <= ST_WAIT;
          end else begin
            state_q    <= ST_IDLE;
          end
        end
        ST_WAIT: if (rsp_take) begin
          level_q <= take_level(mem_rsp_data);
          state_q <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Result registers, updated only on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done               <= 1'b0;
      ea                 <= '0;
      operand            <= '0;
      operand_is_literal <= 1'b0;
      error              <= 1'b0;
    end else begin
      done <= level_final || limit_hit;
      if (level_final) begin
        ea                 <= level_addr;
        operand            <= lit_mode_q ? INSTR_W'(level_addr) : '0;
        operand_is_literal <= lit_mode_q;
        error              <= 1'b0;
      end else if (limit_hit) begin
        ea                 <= level_addr;
        operand            <= '0;
        operand_is_literal <= 1'b0;
        error              <= 1'b1;
      end
    end
  end

  assign start_ready   = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_WAIT);
  assign mem_req_addr  = req_addr_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !start_ready);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  literal_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && operand_is_literal) |-> (operand == INSTR_W'(ea)));

  // R3
  nonliteral_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !operand_is_literal) |-> (operand == '0));

  // R10
  error_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (!operand_is_literal && $past(mem_req_valid || in_eval)));
endmodule

// File: tb/eaddr_resolver_test.sv
module eaddr_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] instr = '0;
  logic [17:0] idx1 = 18'h00100;
  logic [17:0] idx2 = 18'h3FF00;
  logic [17:0] idx3 = 18'h25A5A;
  logic        mem_req_valid;
  logic [17:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [17:0] ea;
  logic [31:0] operand;
  logic        operand_is_literal;
  logic        error;

  localparam int DEPTH = 16;

  eaddr_resolver uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .instr(instr), .idx1(idx1), .idx2(idx2), .idx3(idx3),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .ea(ea), .operand(operand),
    .operand_is_literal(operand_is_literal), .error(error)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int lat = 0;
  int got_n = 0;
  logic [17:0] got_addr [64];
  logic [31:0] mem [int];

  int exp_n;
  logic [17:0] exp_addr [64];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Background content: pointer-free words with junk in spare and literal bits
  function automatic logic [31:0] fill_word(input int a);
    logic [16:0] f;
    f = 17'(a) ^ 17'h0F0F0;
    return {1'b0, 2'(a >> 2), 1'b1, 11'h3C3, f};
  endfunction

  function automatic logic [31:0] mem_rd(input int a);
    if (mem.exists(a)) return mem[a];
    return fill_word(a);
  endfunction

  function automatic logic [17:0] lvl_sum(input logic [31:0] w);
    logic [17:0] base;
    base = {1'b0, w[16:0]};
    case (w[30:29])
      2'd1: return base + idx1;
      2'd2: return base + idx2;
      2'd3: return base + idx3;
      default: return base;
    endcase
  endfunction

  task automatic model(input logic [31:0] ins, output logic [17:0] m_ea,
                       output logic [31:0] m_op, output bit m_lit, output bit m_err);
    logic [31:0] w;
    logic [17:0] a;
    w = ins;
    exp_n = 0;
    forever begin
      a = lvl_sum(w);
      if (!w[31]) begin
        m_ea = a; m_lit = ins[28]; m_op = ins[28] ? {14'd0, a} : 32'd0; m_err = 1'b0;
        return;
      end
      if (exp_n == DEPTH) begin
        m_ea = a; m_lit = 1'b0; m_op = 32'd0; m_err = 1'b1;
        return;
      end
      exp_addr[exp_n] = a;
      exp_n++;
      w = mem_rd(int'(a));
    end
  endtask

  // Memory responder
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      else if (mem_req_valid) begin
        if (wcnt >= lat) begin
          mem_rsp_data  = mem_rd(int'(mem_req_addr));
          mem_rsp_valid = 1'b1;
          if (got_n < 64) got_addr[got_n] = mem_req_addr;
          got_n++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic run(input logic [31:0] ins, input int lat_cfg, input bit poke);
    logic [17:0] m_ea;
    logic [31:0] m_op;
    bit m_lit, m_err, addr_ok;
    int cycles;
    string mtag;
    model(ins, m_ea, m_op, m_lit, m_err);
    mtag = !ins[31] ? (ins[28] ? "R4" : "R3") : (ins[28] ? "R7" : "R5");
    lat = lat_cfg;
    got_n = 0;
    @(negedge clk);
    instr = ins;
    start_valid = 1'b1;
    @(negedge clk);
    cycles = 1;
    while (!done && cycles < 400) begin
      if (poke && cycles < 8) begin
        start_valid = 1'b1;
        instr = ~ins;
        if (cycles == 3) check(!start_ready, "R8", start_ready, 0);
      end else start_valid = 1'b0;
      @(negedge clk);
      cycles++;
    end
    start_valid = 1'b0;
    check(done, "R9", done, 1);
    check(ea == m_ea, "R2", ea, m_ea);
    check(operand == m_op, mtag, operand, m_op);
    check(operand_is_literal == m_lit, "R1", operand_is_literal, m_lit);
    check(error == m_err, m_err ? "R10" : "R9", error, m_err);
    check(got_n == exp_n, ins[31] ? "R5" : mtag, got_n, exp_n);
    addr_ok = (got_n == exp_n);
    for (int k = 0; k < exp_n && k < 64; k++)
      if (got_addr[k] != exp_addr[k]) addr_ok = 1'b0;
    if (ins[31]) check(addr_ok, "R6", addr_ok, 1);
    if (!ins[31] && !poke) check(cycles == 2, "R3", cycles, 2);
    @(negedge clk);
    check(!done, "R9", done, 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [16:0] fields [4];
    int run_i;
    fields[0] = 17'h00000; fields[1] = 17'h1FFFF;
    fields[2] = 17'h00AB5; fields[3] = 17'h15555;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(start_ready && !done && !mem_req_valid, "R11", {start_ready, done, mem_req_valid}, 3'b100);
    check(ea == 0 && operand == 0 && !operand_is_literal && !error, "R11", {ea, operand}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: select x indirect x literal x field, junk in bits 27:17 (R1)
    run_i = 0;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 2; i++)
        for (int l = 0; l < 2; l++)
          for (int f = 0; f < 4; f++) begin
            run({1'(i), 2'(s), 1'(l), 11'h5A5, fields[f]}, run_i % 3, 1'b0);
            run_i++;
          end

    // R6: three-level chain, a different select code at each level
    mem[18'h00AB5 + 18'h00100] = {1'b1, 2'd2, 1'b0, 11'h0, 17'h00200};
    mem[int'(18'h00200 + 18'h3FF00)] = {1'b1, 2'd3, 1'b1, 11'h7FF, 17'h01000};
    run({1'b1, 2'd1, 1'b0, 11'h0, 17'h00AB5}, 1, 1'b0);
    run({1'b1, 2'd1, 1'b1, 11'h0, 17'h00AB5}, 2, 1'b0);

    // R10 boundary: chain ending exactly on read 16 succeeds
    for (int k = 0; k < 15; k++)
      mem[32'h200 + k] = {1'b1, 2'd0, 1'b0, 11'h0, 17'(32'h200 + k + 1)};
    run({1'b1, 2'd0, 1'b1, 11'h0, 17'h00200}, 0, 1'b0);
    // one level longer: error; also R8 start attempts while busy
    mem[32'h1FF] = {1'b1, 2'd0, 1'b0, 11'h0, 17'h00200};
    run({1'b1, 2'd0, 1'b0, 11'h0, 17'h001FF}, 0, 1'b1);
    // self-pointing word
    mem[32'h123] = {1'b1, 2'd0, 1'b0, 11'h0, 17'h00123};
    run({1'b1, 2'd0, 1'b1, 11'h0, 17'h00123}, 1, 1'b0);
    // R9: normal run after an error clears the flag
    run({1'b0, 2'd3, 1'b1, 11'h0, 17'h1FFFF}, 0, 1'b0);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule